// File: doc/BRIEF.md
# Fast PWM Timer with Two Compare Channels

A 16-bit up-counting timer for single-slope pulse-width modulation. On every enabled tick the counter steps up by one, and on the tick where it equals the period limit (TOP) it returns to zero. Each of two compare channels drives one waveform pin. The pin level is set or cleared when the counter equals the channel's compare value, and is restored at the TOP-to-zero turnover.

TOP comes from one of several sources: a fixed 8-, 9- or 10-bit limit, a dedicated period register that takes effect at once, or channel A's own compare value. Compare values are written to a holding register and only become active at the next turnover, so a duty or period change never cuts a cycle short. A prescaler divides the clock to produce the tick. A sticky flag records each turnover.

Top module: `fpwm_timer`

## Requirements
- R1: While `rst` is high, `count` is 0, `ovf_flag` is 0, both waveform pins are 0 and the period register holds 0xFFFF.
- R2: On each tick the count rises by one, or becomes 0 when it equals TOP. The `top_sel` codes select TOP as follows: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, 3 gives the period register, 4 gives channel A's active compare value, and 5 to 7 give 0xFFFF.
- R3: A write to the period register (`wr_top`) is used from the next clock on. If the new value is below the count, the counter runs on to 0xFFFF and wraps to 0 without setting the flag, and only matches TOP after that.
- R4: Compare writes go to a holding register. The active value is copied from it on the tick where the count equals TOP, which is the same tick that zeroes the counter and sets the flag. Under code 4 a new TOP therefore takes effect from the following period.
- R5: `ovf_flag` is set by every turnover tick and stays set until `clr_ovf` is pulsed. A clear that arrives on the same cycle as a turnover leaves the flag set.
- R6: Mode 2 drives the pin high at the turnover and low after the tick where the count equals the compare value, so the pin is high for compare+1 ticks out of TOP+1. Mode 3 gives the opposite levels.
- R7: A compare value of 0 in mode 2 gives a pulse one tick wide in every period.
- R8: A compare value equal to TOP gives a constant level: high in mode 2 and low in mode 3. When the turnover and the match coincide, the turnover wins.
- R9: A compare value above TOP never matches, so in mode 2 the pin stays at its turnover level (high).
- R10: Mode 1 on channel A under code 4 toggles the pin at each match. With a compare value of 0 and a divide ratio of 1, the pin toggles on every clock.
- R11: Mode 0 drives the pin low from the next clock on. So does mode 1 on channel B, and so does mode 1 on channel A under any code other than 4.
- R12: Under codes 0, 1 and 2, compare writes keep only the low 8, 9 or 10 bits and clear the rest.
- R13: `presc_sel` codes 0 to 4 divide the clock by 1, 8, 64, 256 and 1024. A tick falls on each clock where the number of cycles since reset, modulo N, equals N-1. Codes 5 to 7 stop the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 3 | Tick divide ratio select |
| top_sel | input | 3 | TOP source select |
| wr_data | input | 16 | Write data for the compare and period registers |
| wr_cmp_a | input | 1 | Write pulse for channel A's compare holding register |
| wr_cmp_b | input | 1 | Write pulse for channel B's compare holding register |
| wr_top | input | 1 | Write pulse for the period register |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| clr_ovf | input | 1 | Clear pulse for the turnover flag |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| ovf_flag | output | 1 | Sticky turnover flag |
| count | output | 16 | Counter value |

## Verification
The assertions rely on reset being held through the first clock edge and on writes and clears arriving as one-clock pulses. They hold for any ordering of mode and source changes. The stimulus changes `top_sel` only at a negative edge where `count` reads zero, so every overshoot past TOP comes from a deliberate low write to the period register, never from a source switch. Every input changes just after a falling edge, so each rising edge sees stable values.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  localparam logic [2:0] TS_FIX0 = 3'd0;
  localparam logic [2:0] TS_FIX1 = 3'd1;
  localparam logic [2:0] TS_FIX2 = 3'd2;
  localparam logic [2:0] TS_REG  = 3'd3;
  localparam logic [2:0] TS_CHA  = 3'd4;

  localparam logic [1:0] OM_OFF     = 2'd0;
  localparam logic [1:0] OM_TOGGLE  = 2'd1;
  localparam logic [1:0] OM_SET_BOT = 2'd2;
  localparam logic [1:0] OM_CLR_BOT = 2'd3;

  localparam int N_DIV = 5;
  localparam int DIV_LOG [N_DIV] = '{0, 3, 6, 8, 10};

  function automatic int unsigned low_ones(input int unsigned bits);
    return (32'd1 << bits) - 32'd1;
  endfunction
endpackage

// File: rtl/fpwm_prescale.sv
module fpwm_prescale import fpwm_pkg::*; #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) pcnt_q <= '0;
    else     pcnt_q <= pcnt_q + 1'b1;
  end

  // A tick falls where the low log2(N) bits of the free-running count are all ones.
  always_comb begin
    tick = 1'b0;
    mask = '0;
    for (int i = 0; i < N_DIV; i++) begin
      if (sel == 3'(i)) begin
        mask = PRE_W'(low_ones(DIV_LOG[i]));
        tick = ((pcnt_q & mask) == mask);
      end
    end
  end
endmodule

// File: rtl/fpwm_counter.sv
module fpwm_counter import fpwm_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int RES0  = 8,
  parameter int RES1  = 9,
  parameter int RES2  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [2:0]       top_sel,
  input  logic             wr_top,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [CNT_W-1:0] cha_act,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_top,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] TOP0 = CNT_W'(low_ones(RES0));
  localparam logic [CNT_W-1:0] TOP1 = CNT_W'(low_ones(RES1));
  localparam logic [CNT_W-1:0] TOP2 = CNT_W'(low_ones(RES2));

  logic [CNT_W-1:0] top_reg_q;
  logic [CNT_W-1:0] top_val;
  logic             turn;

  always_ff @(posedge clk) begin
    if (rst)         top_reg_q <= '1;
    else if (wr_top) top_reg_q <= wr_data;
  end

  always_comb begin
    case (top_sel)
      TS_FIX0: top_val = TOP0;
      TS_FIX1: top_val = TOP1;
      TS_FIX2: top_val = TOP2;
      TS_REG:  top_val = top_reg_q;
      TS_CHA:  top_val = cha_act;
      default: top_val = '1;
    endcase
  end

  assign at_top = (cnt_q == top_val);
  assign turn   = tick && at_top;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (turn) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          ovf_q <= 1'b0;
    else if (turn)    ovf_q <= 1'b1;
    else if (clr_ovf) ovf_q <= 1'b0;
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && at_top) |=> (cnt_q == '0));
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !at_top) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  p_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && at_top) |=> ovf_q);
  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_ovf) |=> ovf_q);
endmodule

// File: rtl/fpwm_channel.sv
module fpwm_channel import fpwm_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int RES0      = 8,
  parameter int RES1      = 9,
  parameter int RES2      = 10,
  parameter bit TOGGLE_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             at_top,
  input  logic [CNT_W-1:0] cnt,
  input  logic [2:0]       top_sel,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       mode,
  output logic [CNT_W-1:0] act_q,
  output logic             wave_q
);
  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] mask;
  logic             disc;
  logic             match;

  always_comb begin
    case (top_sel)
      TS_FIX0: mask = CNT_W'(low_ones(RES0));
      TS_FIX1: mask = CNT_W'(low_ones(RES1));
      TS_FIX2: mask = CNT_W'(low_ones(RES2));
      default: mask = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     buf_q <= '0;
    else if (wr) buf_q <= wr_data & mask;
  end

  always_ff @(posedge clk) begin
    if (rst)                  act_q <= '0;
    else if (tick && at_top)  act_q <= buf_q;
  end

  assign disc  = (mode == OM_OFF) ||
                 ((mode == OM_TOGGLE) && !(TOGGLE_OK && (top_sel == TS_CHA)));
  assign match = (cnt == act_q);

  always_ff @(posedge clk) begin
    if (rst)       wave_q <= 1'b0;
    else if (disc) wave_q <= 1'b0;
    else if (tick) begin
      case (mode)
        OM_TOGGLE:  if (match) wave_q <= ~wave_q;
        OM_SET_BOT: if (at_top) wave_q <= 1'b1; else if (match) wave_q <= 1'b0;
        default:    if (at_top) wave_q <= 1'b0; else if (match) wave_q <= 1'b1;
      endcase
    end
  end

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && at_top) |=> (act_q == $past(buf_q)));
  p_keep_r4: assert property (@(posedge clk) disable iff (rst)
    !(tick && at_top) |=> $stable(act_q));
  p_off_r11: assert property (@(posedge clk) disable iff (rst)
    (mode == OM_OFF) |=> !wave_q);
  p_bottom_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && at_top && (mode == OM_SET_BOT)) |=> wave_q);
  p_mask_r12: assert property (@(posedge clk) disable iff (rst)
    (wr && (top_sel == TS_FIX0)) |=> ((buf_q & ~CNT_W'(low_ones(RES0))) == '0));
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer import fpwm_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10,
  parameter int RES0  = 8,
  parameter int RES1  = 9,
  parameter int RES2  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       presc_sel,
  input  logic [2:0]       top_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             wr_cmp_a,
  input  logic             wr_cmp_b,
  input  logic             wr_top,
  input  logic [1:0]       mode_a,
  input  logic [1:0]       mode_b,
  input  logic             clr_ovf,
  output logic             wave_a,
  output logic             wave_b,
  output logic             ovf_flag,
  output logic [CNT_W-1:0] count
);
  localparam int N_CH = 2;

  logic             tick;
  logic             at_top;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W-1:0] act   [N_CH];
  logic             wave  [N_CH];
  logic             wr_ch [N_CH];
  logic [1:0]       md_ch [N_CH];

  assign wr_ch[0] = wr_cmp_a;
  assign wr_ch[1] = wr_cmp_b;
  assign md_ch[0] = mode_a;
  assign md_ch[1] = mode_b;

  fpwm_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sel(presc_sel), .tick(tick)
  );

  fpwm_counter #(.CNT_W(CNT_W), .RES0(RES0), .RES1(RES1), .RES2(RES2)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .top_sel(top_sel), .wr_top(wr_top),
    .wr_data(wr_data), .cha_act(act[0]), .clr_ovf(clr_ovf),
    .cnt_q(cnt_q), .at_top(at_top), .ovf_q(ovf_q)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    fpwm_channel #(
      .CNT_W(CNT_W), .RES0(RES0), .RES1(RES1), .RES2(RES2), .TOGGLE_OK(c == 0)
    ) u_ch (
      .clk(clk), .rst(rst), .tick(tick), .at_top(at_top), .cnt(cnt_q),
      .top_sel(top_sel), .wr(wr_ch[c]), .wr_data(wr_data), .mode(md_ch[c]),
      .act_q(act[c]), .wave_q(wave[c])
    );
  end

  assign wave_a   = wave[0];
  assign wave_b   = wave[1];
  assign ovf_flag = ovf_q;
  assign count    = cnt_q;
endmodule

// File: tb/tb_fpwm_timer.sv
`timescale 1ns/1ps
module tb_fpwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  presc_sel = '0;
  logic [2:0]  top_sel = '0;
  logic [15:0] wr_data = '0;
  logic        wr_cmp_a = 1'b0, wr_cmp_b = 1'b0, wr_top = 1'b0;
  logic [1:0]  mode_a = '0, mode_b = '0;
  logic        clr_ovf = 1'b0;
  logic        wave_a, wave_b, ovf_flag;
  logic [15:0] count;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fpwm_timer dut (
    .clk(clk), .rst(rst), .presc_sel(presc_sel), .top_sel(top_sel),
    .wr_data(wr_data), .wr_cmp_a(wr_cmp_a), .wr_cmp_b(wr_cmp_b), .wr_top(wr_top),
    .mode_a(mode_a), .mode_b(mode_b), .clr_ovf(clr_ovf),
    .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag), .count(count)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_pcnt, m_cnt, m_top, m_ovf;
  int m_buf [2];
  int m_act [2];
  int m_wave [2];
  int div, topv, tk, at, md, nw, n_ovf;

  function automatic int mask_of(input int ts);
    case (ts)
      0: return 'hFF;
      1: return 'h1FF;
      2: return 'h3FF;
      default: return 'hFFFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pcnt = 0; m_cnt = 0; m_top = 'hFFFF; m_ovf = 0;
      for (int c = 0; c < 2; c++) begin m_buf[c] = 0; m_act[c] = 0; m_wave[c] = 0; end
    end else begin
      case (presc_sel)
        0: div = 1; 1: div = 8; 2: div = 64; 3: div = 256; 4: div = 1024;
        default: div = 0;
      endcase
      tk = (div != 0 && (m_pcnt % div) == div - 1) ? 1 : 0;
      m_pcnt = (m_pcnt + 1) % 1024;
      case (top_sel)
        0: topv = 'hFF; 1: topv = 'h1FF; 2: topv = 'h3FF;
        3: topv = m_top; 4: topv = m_act[0];
        default: topv = 'hFFFF;
      endcase
      at = (m_cnt == topv) ? 1 : 0;
      for (int c = 0; c < 2; c++) begin
        md = (c == 0) ? int'(mode_a) : int'(mode_b);
        nw = m_wave[c];
        if (md == 0 || (md == 1 && (c == 1 || top_sel != 3'd4))) nw = 0;
        else if (tk == 1) begin
          if (md == 1) begin
            if (m_cnt == m_act[c]) nw = 1 - nw;
          end else begin
            if (at == 1) nw = (md == 2) ? 1 : 0;
            else if (m_cnt == m_act[c]) nw = (md == 2) ? 0 : 1;
          end
        end
        m_wave[c] = nw;
      end
      n_ovf = m_ovf;
      if (tk == 1 && at == 1) n_ovf = 1; else if (clr_ovf) n_ovf = 0;
      m_ovf = n_ovf;
      if (tk == 1) m_cnt = (at == 1) ? 0 : (m_cnt + 1) % 65536;
      if (tk == 1 && at == 1) begin m_act[0] = m_buf[0]; m_act[1] = m_buf[1]; end
      if (wr_cmp_a) m_buf[0] = int'(wr_data) & mask_of(int'(top_sel));
      if (wr_cmp_b) m_buf[1] = int'(wr_data) & mask_of(int'(top_sel));
      if (wr_top) m_top = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(count) == m_cnt, "R2 count vs model", count, m_cnt);
      chk(int'(ovf_flag) == m_ovf, "R5 flag vs model", ovf_flag, m_ovf);
      chk(int'(wave_a) == m_wave[0], "R6 wave_a vs model", wave_a, m_wave[0]);
      chk(int'(wave_b) == m_wave[1], "R6 wave_b vs model", wave_b, m_wave[1]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic write_reg(input int which, input int v);
    wr_data = 16'(v);
    if (which == 0) wr_cmp_a = 1'b1;
    else if (which == 1) wr_cmp_b = 1'b1;
    else wr_top = 1'b1;
    @(negedge clk);
    wr_cmp_a = 1'b0; wr_cmp_b = 1'b0; wr_top = 1'b0;
  endtask

  task automatic wait_cnt(input int v, input int lim, input string req);
    int n = 0;
    while (int'(count) != v && n < lim) begin @(negedge clk); n++; end
    chk(n < lim, req, count, v);
  endtask

  task automatic highs(input bit sel_b, input int n, output int h);
    h = 0;
    repeat (n) begin @(negedge clk); h += sel_b ? int'(wave_b) : int'(wave_a); end
  endtask

  task automatic spacing(output int n);
    logic [15:0] p;
    p = count;
    while (count == p) @(negedge clk);
    p = count; n = 0;
    while (count == p && n < 3000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int h;
    logic pv;
    repeat (4) @(negedge clk);
    chk(count == 0 && !ovf_flag && !wave_a && !wave_b, "R1 reset state",
        {count, ovf_flag, wave_a, wave_b}, 0);
    rst = 1'b0;

    mode_a = 2'd2; mode_b = 2'd3;
    write_reg(0, 'h40); write_reg(1, 'h40);
    repeat (600) @(negedge clk);
    highs(0, 256, h); chk(h == 'h41, "R6 mode2 high time", h, 'h41);
    highs(1, 256, h); chk(h == 256 - 'h41, "R6 mode3 high time", h, 256 - 'h41);

    write_reg(0, 0); repeat (600) @(negedge clk);
    highs(0, 256, h); chk(h == 1, "R7 spike width", h, 1);

    write_reg(0, 'hFF); write_reg(1, 'hFF); repeat (600) @(negedge clk);
    highs(0, 256, h); chk(h == 256, "R8 mode2 at TOP", h, 256);
    highs(1, 256, h); chk(h == 0, "R8 mode3 at TOP", h, 0);

    write_reg(0, 'h1234); repeat (600) @(negedge clk);
    highs(0, 256, h); chk(h == 'h35, "R12 masked to 8 bits", h, 'h35);
    wait_cnt(0, 400, "R2 wait zero");
    top_sel = 3'd1;
    write_reg(0, 'hFFFF); repeat (1100) @(negedge clk);
    highs(0, 512, h); chk(h == 512, "R12 masked to 9 bits", h, 512);

    wait_cnt(0, 700, "R2 wait zero");
    top_sel = 3'd3;
    write_reg(2, 'h80); write_reg(1, 'h100); mode_b = 2'd2;
    repeat (400) @(negedge clk);
    highs(1, 129, h); chk(h == 129, "R9 compare above TOP", h, 129);

    wait_cnt('h80, 200, "R5 wait TOP");
    clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
    chk(ovf_flag == 1'b1, "R5 set wins over clear", ovf_flag, 1);
    clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
    chk(ovf_flag == 1'b0, "R5 clear", ovf_flag, 0);
    repeat (20) @(negedge clk);
    chk(ovf_flag == 1'b0, "R5 stays clear", ovf_flag, 0);

    write_reg(2, 'h400);
    wait_cnt('h300, 2000, "R3 reach 0x300");
    clr_ovf = 1'b1; write_reg(2, 'h100); clr_ovf = 1'b0;
    wait_cnt('hFFFF, 70000, "R3 overshoot to max");
    chk(ovf_flag == 1'b0, "R3 no flag at max", ovf_flag, 0);
    @(negedge clk);
    chk(count == 0 && !ovf_flag, "R3 wrap without flag", {count, ovf_flag}, 0);
    wait_cnt('h100, 400, "R3 reach new TOP");
    @(negedge clk);
    chk(count == 0 && ovf_flag, "R3 match after wrap", {count, ovf_flag}, 1);

    write_reg(0, 'h20);
    wait_cnt('h100, 400, "R4 wait TOP");
    @(negedge clk);
    top_sel = 3'd4;
    wait_cnt(5, 40, "R4 wait 5");
    write_reg(0, 'h10);
    wait_cnt('h20, 40, "R4 old TOP still active");
    @(negedge clk); chk(count == 0, "R4 turnover at old TOP", count, 0);
    wait_cnt('h10, 40, "R4 new TOP reached");
    @(negedge clk); chk(count == 0, "R4 turnover at new TOP", count, 0);

    mode_a = 2'd1; write_reg(0, 0);
    repeat (40) @(negedge clk);
    pv = wave_a;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(wave_a != pv && count == 0, "R10 toggle every clock", wave_a, !pv);
      pv = wave_a;
    end

    top_sel = 3'd0;
    repeat (2) @(negedge clk);
    chk(wave_a == 1'b0, "R11 toggle needs code 4", wave_a, 0);
    mode_b = 2'd1; repeat (2) @(negedge clk);
    chk(wave_b == 1'b0, "R11 mode1 on B", wave_b, 0);
    mode_a = 2'd0; mode_b = 2'd2;
    highs(0, 300, h); chk(h == 0, "R11 mode0 low", h, 0);

    presc_sel = 3'd1; spacing(h); chk(h == 8, "R13 divide 8", h, 8);
    presc_sel = 3'd4; spacing(h); chk(h == 1024, "R13 divide 1024", h, 1024);
    presc_sel = 3'd6; @(negedge clk);
    h = int'(count); repeat (2000) @(negedge clk);
    chk(int'(count) == h, "R13 stopped", count, h);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule